// File: doc/BRIEF.md
# External Interrupt Request Flag Unit

This block keeps one pending flag for each of sixteen external interrupt request pins. Each pin has a 2-bit sense-mode setting that selects what sets its flag: a low input level, a falling edge, a rising edge, or either edge. Edges are found by comparing the already-synchronized pin with a copy of it held one cycle earlier. The flags go out as a 16-bit pending vector to a downstream arbiter. They can also be seen as two 8-bit bytes on a small register bus.

Software clears a flag in two steps. First it reads the flag while the flag holds 1. Then it writes 0 to that bit. A hidden per-flag marker records the qualifying read.

Hardware clears a flag when the CPU acknowledges that interrupt number. For an edge-mode pin, acknowledgement always clears the flag. For a level-mode pin, it clears the flag only if the pin is high at that moment. In any cycle, a new set condition takes precedence over every clear.

Top module: `irqf_unit`

## Requirements
- R1: After reset every flag is 0, so `pending` reads 0 and both bus bytes read 0x00.
- R2: `pending[n]` is flag n. A read of `bus_addr`=1 returns flags 15..8 on `bus_rdata[7:0]`, and `bus_addr`=0 returns flags 7..0. `bus_rdata` follows the addressed flags in the same cycle.
- R3: Sense mode 2'b00 (low level) sets flag n at every clock edge where pin n is 0.
- R4: Sense mode 2'b01 (falling edge) sets flag n when pin n is 0 and was 1 one cycle earlier.
- R5: Sense mode 2'b10 (rising edge) sets flag n when pin n is 1 and was 0 one cycle earlier. A falling edge on such a pin has no effect.
- R6: Sense mode 2'b11 (both edges) sets flag n on any change of pin n.
- R7: A bus write that has bit n%8 at 0 clears flag n only when flag n was read as 1 earlier. That read must have come after the flag's last clear and after the last write to its byte.
- R8: Writing 1 to a bit never sets or changes a flag. Writing 0 without a qualifying earlier read leaves the flag unchanged.
- R9: When `ack_valid` is high and `ack_num`=n, flag n clears if pin n is in an edge mode.
- R10: When `ack_valid` is high and `ack_num`=n, flag n clears if pin n is in level mode and pin n is 1 in that cycle. It stays set if pin n is 0.
- R11: A set condition in the same cycle as a software or acknowledge clear leaves the flag at 1.
- R12: Pin n takes its sense mode from `sense_cfg[2n+1:2n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_pin | input | 16 | Synchronized request pins |
| sense_cfg | input | 32 | Sense mode per pin, 2 bits each |
| bus_addr | input | 1 | Byte select: 1 selects flags 15..8, 0 selects flags 7..0 |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_num | input | 4 | Number of the acknowledged request |
| pending | output | 16 | Flag vector for the arbiter |

## Verification
Every flag is visible at the ports on the cycle after it changes, so a wrong set or a wrong clear shows up on `pending` within one clock. A corrupted edge-history bit first shows as a set that is missing or spurious at the next pin transition. A wrong read marker stays hidden until a later write of 0. At that point, a stuck-high marker clears a flag that should have survived, and a lost marker keeps a flag that should have cleared. The bench therefore interleaves reads, writes and acknowledges randomly, so that marker errors reach `pending` within a few cycles.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irqf_rst_sync.sv
module irqf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqf_sense.sv
module irqf_sense
  import irqf_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   pin_i,
  input  logic [2*NUM_IRQ-1:0] mode_i,
  output logic [NUM_IRQ-1:0]   hit_o
);
  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] prev_d;

  always_comb prev_d = pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_pin
    sense_e mode;
    assign mode = sense_e'(mode_i[2*n +: 2]);
    always_comb begin
      unique case (mode)
        SENSE_LOW:  hit_o[n] = ~pin_i[n];
        SENSE_FALL: hit_o[n] = prev_q[n] & ~pin_i[n];
        SENSE_RISE: hit_o[n] = ~prev_q[n] & pin_i[n];
        default:    hit_o[n] = prev_q[n] ^ pin_i[n];
      endcase
    end

    // R5
    rise_ignores_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SENSE_RISE && !pin_i[n]) |-> !hit_o[n]);
  end
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic seen_q, seen_d;
  logic sw_clr;

  always_comb begin
    sw_clr = wr_hit_i & ~wbit_i & seen_q;
    flag_d = set_i | (flag_q & ~hw_clr_i & ~sw_clr);
    seen_d = ((rd_hit_i & flag_q) | (seen_q & ~wr_hit_i)) & flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      seen_q <= seen_d;
    end
  end

  assign flag_o = flag_q;

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R8
  no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !flag_o) |=> !flag_o);
  // R7
  guarded_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !set_i && !hw_clr_i && !seen_q) |=> flag_o);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/irqf_unit.sv
module irqf_unit
  import irqf_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int BYTE_W  = 8,
  localparam int NUM_BYTES = NUM_IRQ / BYTE_W,
  localparam int ADDR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int ACK_W     = $clog2(NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_pin,
  input  logic [2*NUM_IRQ-1:0] sense_cfg,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [BYTE_W-1:0]    bus_wdata,
  output logic [BYTE_W-1:0]    bus_rdata,
  input  logic                 ack_valid,
  input  logic [ACK_W-1:0]     ack_num,
  output logic [NUM_IRQ-1:0]   pending
);
  logic               rst_sync_n;
  logic [NUM_IRQ-1:0] set_hit;
  logic [NUM_IRQ-1:0] flags;

  irqf_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  irqf_sense #(.NUM_IRQ(NUM_IRQ)) u_sense (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (irq_pin),
    .mode_i (sense_cfg),
    .hit_o  (set_hit)
  );

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_flag
    logic sel_byte, ack_hit, hw_clr;
    always_comb begin
      sel_byte = (bus_addr == ADDR_W'(n / BYTE_W));
      ack_hit  = ack_valid && (ack_num == ACK_W'(n));
      hw_clr   = ack_hit &&
                 ((sense_e'(sense_cfg[2*n +: 2]) != SENSE_LOW) || irq_pin[n]);
    end

    irqf_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .set_i    (set_hit[n]),
      .hw_clr_i (hw_clr),
      .rd_hit_i (bus_rd & sel_byte),
      .wr_hit_i (bus_wr & sel_byte),
      .wbit_i   (bus_wdata[n % BYTE_W]),
      .flag_o   (flags[n])
    );

    // R10
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ack_hit && sense_e'(sense_cfg[2*n +: 2]) == SENSE_LOW && !irq_pin[n])
        |=> flags[n]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (bus_addr == ADDR_W'(b)) bus_rdata = flags[b*BYTE_W +: BYTE_W];
    end
  end

  assign pending = flags;

  // R2
  byte_map_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == '0) |-> (bus_rdata == pending[BYTE_W-1:0]));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (pending == '0));
endmodule

// File: tb/tb_irqf_unit.sv
module tb_irqf_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_pin;
  logic [31:0] sense_cfg;
  logic [0:0]  bus_addr;
  logic        bus_rd, bus_wr, ack_valid;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [3:0]  ack_num;
  logic [15:0] pending;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] m_flag, m_seen, m_prev;
  int          rcnt;

  always #10 clk = ~clk;

  irqf_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .sense_cfg(sense_cfg),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_num(ack_num), .pending(pending)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: behaviour taken from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0; m_flag = '0; m_seen = '0; m_prev = '1;
    end else if (rcnt < 2) begin
      rcnt = rcnt + 1; m_flag = '0; m_seen = '0; m_prev = '1;
    end else begin
      logic [15:0] nf, ns;
      for (int n = 0; n < 16; n++) begin
        int  mode;
        bit  s, hw, sw, inbyte;
        mode = sense_cfg[2*n +: 2];
        case (mode)
          0: s = (irq_pin[n] == 0);
          1: s = (m_prev[n] == 1 && irq_pin[n] == 0);
          2: s = (m_prev[n] == 0 && irq_pin[n] == 1);
          default: s = (m_prev[n] != irq_pin[n]);
        endcase
        inbyte = ((n >= 8) == bus_addr[0]);
        hw = ack_valid && (ack_num == n) && (mode != 0 || irq_pin[n]);
        sw = bus_wr && inbyte && !bus_wdata[n % 8] && m_seen[n];
        nf[n] = s || (m_flag[n] && !hw && !sw);
        ns[n] = nf[n] && ((bus_rd && inbyte && m_flag[n]) || (m_seen[n] && !(bus_wr && inbyte)));
      end
      m_flag = nf; m_seen = ns; m_prev = irq_pin;
    end
  end

  // compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pending", pending, m_flag);
      chk("R2 rdata", {8'h00, bus_rdata}, {8'h00, bus_addr[0] ? m_flag[15:8] : m_flag[7:0]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_bus();
    bus_rd = 0; bus_wr = 0; ack_valid = 0; bus_wdata = '0; ack_num = '0;
  endtask

  initial begin
    rst_n = 0;
    irq_pin = '1;
    bus_addr = 1'b0;
    idle_bus();
    for (int n = 0; n < 16; n++) sense_cfg[2*n +: 2] = 2'(n % 4); // R12 field per pin
    repeat (3) cyc();
    chk("R1 pending in reset", pending, 16'h0000);
    rst_n = 1;
    repeat (4) cyc();
    chk("R1 pending after reset", pending, 16'h0000);
    chk("R1 rdata after reset", {8'h00, bus_rdata}, 16'h0000);

    irq_pin[0] = 1'b1; cyc();
    chk("R3 level pin high no set", {15'h0, pending[0]}, 16'h0);
    irq_pin[1] = 0; cyc();
    chk("R4 falling sets", {15'h0, pending[1]}, 16'h1);
    irq_pin[1] = 1; cyc();
    irq_pin[2] = 0; cyc();
    chk("R5 falling ignored", {15'h0, pending[2]}, 16'h0);
    irq_pin[2] = 1; cyc();
    chk("R5 rising sets", {15'h0, pending[2]}, 16'h1);
    irq_pin[3] = 0; cyc();
    chk("R6 fall sets", {15'h0, pending[3]}, 16'h1);

    bus_addr = 0; bus_rd = 1; cyc();
    bus_rd = 0; bus_wr = 1; bus_wdata = 8'hF7; cyc();
    bus_wr = 0;
    chk("R7 read then write 0 clears", {15'h0, pending[3]}, 16'h0);
    irq_pin[3] = 1; cyc();
    chk("R6 rise sets", {15'h0, pending[3]}, 16'h1);

    bus_wr = 1; bus_wdata = 8'h00; cyc();
    chk("R8 write 0 without read", {8'h00, pending[7:0]}, 16'h000E);
    bus_wdata = 8'hFF; cyc();
    bus_wr = 0;
    chk("R8 write 1 no effect", {8'h00, pending[7:0]}, 16'h000E);

    ack_valid = 1; ack_num = 4'd1; cyc();
    ack_valid = 0;
    chk("R9 edge ack clears", {8'h00, pending[7:0]}, 16'h000C);

    irq_pin[0] = 0; cyc();
    chk("R3 level low sets", {15'h0, pending[0]}, 16'h1);
    ack_valid = 1; ack_num = 4'd0; cyc();
    chk("R10 ack with pin low holds", {15'h0, pending[0]}, 16'h1);
    irq_pin[0] = 1; cyc();
    ack_valid = 0;
    chk("R10 ack with pin high clears", {15'h0, pending[0]}, 16'h0);

    ack_valid = 1; ack_num = 4'd3; irq_pin[3] = 0; cyc();
    ack_valid = 0;
    chk("R11 set beats ack clear", {15'h0, pending[3]}, 16'h1);

    irq_pin[9] = 0; bus_addr = 1; cyc();
    chk("R2 high byte", {8'h00, bus_rdata}, 16'h0002);
    irq_pin[15] = 0; cyc();
    chk("R12 pin15 both-edge field", {8'h00, bus_rdata}, 16'h0082);
    irq_pin[15] = 1; irq_pin[14] = 0; cyc();
    chk("R12 pin14 rising field ignores fall", {14'h0, pending[15:14]}, 16'h2);

    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) sense_cfg = $urandom;
      irq_pin   = ($urandom % 4 == 0) ? 16'($urandom) : irq_pin;
      bus_addr  = 1'($urandom);
      bus_rd    = ($urandom % 3 == 0);
      bus_wr    = ($urandom % 4 == 0);
      bus_wdata = 8'($urandom);
      ack_valid = ($urandom % 4 == 0);
      ack_num   = 4'($urandom);
      cyc();
    end
    idle_bus();
    cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule